// File: doc/BRIEF.md
# Delegated Counter Window Access Unit

This unit lets supervisor software reach the hardware performance counters and their event-selector (configuration) registers through a window, with no dedicated CSR for each counter. A 12-bit window-select register picks a counter slot. Four alias targets then read or write the chosen slot's counter low half, counter high half, configuration low half and configuration high half. A request presents a privilege level, a target code, a write flag and write data in one cycle. The registered response follows one cycle later and carries read data and an exception class.

The unit gates supervisor access on a delegation-enable flag and on a per-counter delegation mask. It picks the exception class from the privilege level and that flag. Through the window it hides the machine-mode inhibit bit of each event selector from anyone below machine mode. It also holds a machine counter-inhibit register, which supervisor software sees through a view masked by the delegation mask. The counters and selectors are plain register arrays. Counting and overflow are handled elsewhere.

Top module: `ctr_deleg_csr`

## Requirements
- R1: The delegation-enable flag is bit 28 of `envcfg_hi_i` (bit 60 of the full environment-configuration value). No other bit of that input changes behaviour.
- R2: Window value 0x40+n selects counter slot n: 0x40 is cycle, 0x42 is instret, 0x43 and up are the general counters. The target codes are 1 = counter low, 3 = counter high, 2 = configuration low, 4 = configuration high. Each half is 32 bits and is stored independently.
- R3: If the window value is 0x41, or lies outside 0x40..0x5F, every alias target reads 0 and ignores writes. Such an access raises no exception when the privilege level otherwise allows it.
- R4: From S-mode, bit 30 of the configuration-high target (event-selector bit 62) reads as 0 and keeps its stored value on writes. From M-mode the window shows and writes that bit unmasked.
- R5: Any alias access from VS-mode (privilege code 2) raises an illegal-instruction exception (exception code 1) when the delegation flag is 0. When the flag is 1 it raises a virtual-instruction exception (exception code 2).
- R6: From S-mode (privilege code 1), an alias access raises an illegal-instruction exception in two cases: the delegation flag is 0, or the selected live slot n has bit n of `deleg_mask_i` clear. In either case no register changes.
- R7: The following raise an illegal-instruction exception: any access from U-mode (code 0), target code 7, and the machine-inhibit target (code 6) from any level but M-mode (code 3). A VS-mode access to the window-select target (code 0) or the supervisor-inhibit target (code 5) raises a virtual-instruction exception. Every excepting response returns read data 0.
- R8: The supervisor-inhibit target reads as machine-inhibit AND `deleg_mask_i`. A write to it changes only the machine-inhibit bits set in the mask.
- R9: Each request gets exactly one response on the next cycle. A window-select write is used by an alias request in the very next cycle. Write responses return data 0.
- R10: After reset, the window-select register, all counter and configuration halves and machine-inhibit are 0, and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_prv_i | input | 2 | Privilege: 0 U, 1 S, 2 VS, 3 M |
| req_tgt_i | input | 3 | Target: 0 window select, 1 ctr lo, 2 cfg lo, 3 ctr hi, 4 cfg hi, 5 supervisor inhibit, 6 machine inhibit, 7 none |
| req_we_i | input | 1 | Write (1) or read (0) |
| req_wdata_i | input | 32 | Write data |
| envcfg_hi_i | input | 32 | Upper half of environment configuration |
| deleg_mask_i | input | 32 | Per-counter delegation mask |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 32 | Read data (0 for writes and exceptions) |
| rsp_exc_o | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |

## Verification
The bound checker watches several things on every cycle: the one-cycle response timing, the choice of exception class for U-mode, VS-mode and undelegated S-mode accesses, zero data on every exception, the hidden selector bit on S-mode reads, the masking of the supervisor-inhibit view, and zero, exception-free reads through a reserved or out-of-range window. Only the bench scenarios can show that state persists or stays put. These cover the mapping of slots to distinct storage, retention of the hidden bit across S-mode writes, writes that must be dropped on an exception or a reserved window, the partial update of machine-inhibit through the supervisor view, and the window-select write being used in the very next cycle.

// File: rtl/ctr_deleg_pkg.sv
package ctr_deleg_pkg;
  typedef enum logic [1:0] {
    PRV_U  = 2'd0,
    PRV_S  = 2'd1,
    PRV_VS = 2'd2,
    PRV_M  = 2'd3
  } prv_e;

  typedef enum logic [2:0] {
    TG_INDEX  = 3'd0,
    TG_CTR_LO = 3'd1,
    TG_CFG_LO = 3'd2,
    TG_CTR_HI = 3'd3,
    TG_CFG_HI = 3'd4,
    TG_SINH   = 3'd5,
    TG_MINH   = 3'd6,
    TG_NONE   = 3'd7
  } tgt_e;

  typedef enum logic [1:0] {
    EX_NONE    = 2'd0,
    EX_ILLEGAL = 2'd1,
    EX_VIRTUAL = 2'd2
  } exc_e;
endpackage

// File: rtl/ctr_deleg_decode.sv
module ctr_deleg_decode
  import ctr_deleg_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int IDX_BASE = 'h40,
  parameter int NSLOT    = 32,
  parameter int RESV_OFF = 1,
  parameter int SLOT_W   = $clog2(NSLOT)
) (
  input  prv_e              prv,
  input  tgt_e              tgt,
  input  logic              cde,
  input  logic [IDX_W-1:0]  index,
  input  logic [NSLOT-1:0]  deleg_mask,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_live,
  output logic              is_alias,
  output exc_e              exc
);
  logic [IDX_W-1:0] off;
  logic             in_win;

  always_comb begin
    off       = index - IDX_W'(IDX_BASE);
    in_win    = (index >= IDX_W'(IDX_BASE)) && (off < IDX_W'(NSLOT));
    slot      = off[SLOT_W-1:0];
    slot_live = in_win && (slot != SLOT_W'(RESV_OFF));
    is_alias  = (tgt == TG_CTR_LO) || (tgt == TG_CTR_HI) ||
                (tgt == TG_CFG_LO) || (tgt == TG_CFG_HI);
  end

  always_comb begin
    exc = EX_NONE;
    if (tgt == TG_NONE || prv == PRV_U) begin
      exc = EX_ILLEGAL;
    end else begin
      unique case (tgt)
        TG_MINH: if (prv != PRV_M) exc = EX_ILLEGAL;
        TG_INDEX, TG_SINH: if (prv == PRV_VS) exc = EX_VIRTUAL;
        default: begin
          if (prv == PRV_VS) begin
            exc = cde ? EX_VIRTUAL : EX_ILLEGAL;
          end else if (prv == PRV_S) begin
            if (!cde) exc = EX_ILLEGAL;
            else if (slot_live && !deleg_mask[slot]) exc = EX_ILLEGAL;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ctr_deleg_store.sv
module ctr_deleg_store
  import ctr_deleg_pkg::*;
#(
  parameter int NSLOT     = 32,
  parameter int XLEN      = 32,
  parameter int GUARD_BIT = 30,
  parameter int SLOT_W    = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tgt_e              tgt,
  input  logic [SLOT_W-1:0] slot,
  input  logic              hide_guard,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   rdata
);
  localparam logic [XLEN-1:0] GMASK = XLEN'(1) << GUARD_BIT;

  logic [XLEN-1:0] ctr_lo_a [NSLOT];
  logic [XLEN-1:0] ctr_hi_a [NSLOT];
  logic [XLEN-1:0] cfg_lo_a [NSLOT];
  logic [XLEN-1:0] cfg_hi_a [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic            sel;
    logic [XLEN-1:0] c_lo_q, c_hi_q, f_lo_q, f_hi_q;
    logic [XLEN-1:0] f_hi_nxt;

    always_comb begin
      sel      = wr_en && (slot == SLOT_W'(g));
      f_hi_nxt = hide_guard ? ((wdata & ~GMASK) | (f_hi_q & GMASK)) : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_lo_q <= '0;
        c_hi_q <= '0;
        f_lo_q <= '0;
        f_hi_q <= '0;
      end else if (sel) begin
        if (tgt == TG_CTR_LO) c_lo_q <= wdata;
        if (tgt == TG_CTR_HI) c_hi_q <= wdata;
        if (tgt == TG_CFG_LO) f_lo_q <= wdata;
        if (tgt == TG_CFG_HI) f_hi_q <= f_hi_nxt;
      end
    end

    assign ctr_lo_a[g] = c_lo_q;
    assign ctr_hi_a[g] = c_hi_q;
    assign cfg_lo_a[g] = f_lo_q;
    assign cfg_hi_a[g] = f_hi_q;
  end

  always_comb begin
    unique case (tgt)
      TG_CTR_LO: rdata = ctr_lo_a[slot];
      TG_CTR_HI: rdata = ctr_hi_a[slot];
      TG_CFG_LO: rdata = cfg_lo_a[slot];
      TG_CFG_HI: rdata = hide_guard ? (cfg_hi_a[slot] & ~GMASK) : cfg_hi_a[slot];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctr_deleg_inhibit.sv
module ctr_deleg_inhibit #(
  parameter int NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_m,
  input  logic             wr_s,
  input  logic [NSLOT-1:0] wdata,
  input  logic [NSLOT-1:0] mask,
  output logic [NSLOT-1:0] minh,
  output logic [NSLOT-1:0] sinh
);
  logic [NSLOT-1:0] minh_q, minh_nxt;
  logic             minh_en;

  always_comb begin
    minh_en  = wr_m || wr_s;
    minh_nxt = wr_m ? wdata : ((minh_q & ~mask) | (wdata & mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       minh_q <= '0;
    else if (minh_en) minh_q <= minh_nxt;
  end

  assign minh = minh_q;
  assign sinh = minh_q & mask;
endmodule

// File: rtl/ctr_deleg_csr.sv
module ctr_deleg_csr
  import ctr_deleg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IDX_W     = 12,
  parameter int IDX_BASE  = 'h40,
  parameter int NSLOT     = 32,
  parameter int RESV_OFF  = 1,
  parameter int CDE_BIT   = 28,
  parameter int GUARD_BIT = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [1:0]       req_prv_i,
  input  logic [2:0]       req_tgt_i,
  input  logic             req_we_i,
  input  logic [XLEN-1:0]  req_wdata_i,
  input  logic [XLEN-1:0]  envcfg_hi_i,
  input  logic [NSLOT-1:0] deleg_mask_i,
  output logic             rsp_valid_o,
  output logic [XLEN-1:0]  rsp_rdata_o,
  output logic [1:0]       rsp_exc_o
);
  localparam int SLOT_W = $clog2(NSLOT);

  prv_e              prv;
  tgt_e              tgt;
  logic              cde;
  logic              cfg_unused;
  logic [IDX_W-1:0]  index_q, index_nxt;
  logic              index_en;
  logic [SLOT_W-1:0] slot;
  logic              slot_live, is_alias;
  exc_e              exc;
  logic              commit, wr_ok;
  logic [XLEN-1:0]   store_rd, rd_sel;
  logic [NSLOT-1:0]  minh, sinh;
  logic              rsp_valid_q;
  logic [XLEN-1:0]   rsp_rdata_q, rsp_rdata_nxt;
  logic [1:0]        rsp_exc_q, rsp_exc_nxt;

  assign prv        = prv_e'(req_prv_i);
  assign tgt        = tgt_e'(req_tgt_i);
  assign cde        = envcfg_hi_i[CDE_BIT];
  assign cfg_unused = ^envcfg_hi_i;

  ctr_deleg_decode #(
    .IDX_W(IDX_W), .IDX_BASE(IDX_BASE), .NSLOT(NSLOT),
    .RESV_OFF(RESV_OFF), .SLOT_W(SLOT_W)
  ) u_dec (
    .prv(prv), .tgt(tgt), .cde(cde), .index(index_q),
    .deleg_mask(deleg_mask_i), .slot(slot), .slot_live(slot_live),
    .is_alias(is_alias), .exc(exc)
  );

  assign commit = req_valid_i && (exc == EX_NONE);
  assign wr_ok  = commit && req_we_i;

  ctr_deleg_store #(
    .NSLOT(NSLOT), .XLEN(XLEN), .GUARD_BIT(GUARD_BIT), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok && is_alias && slot_live),
    .tgt(tgt), .slot(slot), .hide_guard(prv != PRV_M),
    .wdata(req_wdata_i), .rdata(store_rd)
  );

  ctr_deleg_inhibit #(.NSLOT(NSLOT)) u_inh (
    .clk(clk), .rst_n(rst_n),
    .wr_m(wr_ok && tgt == TG_MINH),
    .wr_s(wr_ok && tgt == TG_SINH),
    .wdata(req_wdata_i[NSLOT-1:0]), .mask(deleg_mask_i),
    .minh(minh), .sinh(sinh)
  );

  always_comb begin
    index_en  = wr_ok && (tgt == TG_INDEX);
    index_nxt = req_wdata_i[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        index_q <= '0;
    else if (index_en) index_q <= index_nxt;
  end

  always_comb begin
    unique case (tgt)
      TG_INDEX: rd_sel = XLEN'(index_q);
      TG_SINH:  rd_sel = XLEN'(sinh);
      TG_MINH:  rd_sel = XLEN'(minh);
      default:  rd_sel = slot_live ? store_rd : '0;
    endcase
    rsp_rdata_nxt = (commit && !req_we_i) ? rd_sel : '0;
    rsp_exc_nxt   = req_valid_i ? exc : EX_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_exc_q   <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_rdata_q <= rsp_rdata_nxt;
      rsp_exc_q   <= rsp_exc_nxt;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_exc_o   = rsp_exc_q;
endmodule

// File: rtl/ctr_deleg_chk.sv
module ctr_deleg_chk
  import ctr_deleg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IDX_W     = 12,
  parameter int IDX_BASE  = 'h40,
  parameter int NSLOT     = 32,
  parameter int RESV_OFF  = 1,
  parameter int CDE_BIT   = 28,
  parameter int GUARD_BIT = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic [1:0]       req_prv_i,
  input logic [2:0]       req_tgt_i,
  input logic             req_we_i,
  input logic [XLEN-1:0]  envcfg_hi_i,
  input logic [NSLOT-1:0] deleg_mask_i,
  input logic             rsp_valid_o,
  input logic [XLEN-1:0]  rsp_rdata_o,
  input logic [1:0]       rsp_exc_o,
  input logic [IDX_W-1:0] index_q
);
  logic alias_req, dead_win;

  assign alias_req = req_valid_i && (req_tgt_i >= 3'd1) && (req_tgt_i <= 3'd4);
  assign dead_win  = (index_q < IDX_W'(IDX_BASE)) ||
                     (index_q >= IDX_W'(IDX_BASE + NSLOT)) ||
                     (index_q == IDX_W'(IDX_BASE + RESV_OFF));

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o); // R9
  AST_RSP_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o); // R9
  AST_VS_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_req && req_prv_i == PRV_VS && !envcfg_hi_i[CDE_BIT]) |=> rsp_exc_o == EX_ILLEGAL); // R5
  AST_VS_VIRTUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_req && req_prv_i == PRV_VS && envcfg_hi_i[CDE_BIT]) |=> rsp_exc_o == EX_VIRTUAL); // R5
  AST_S_NO_CDE: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_req && req_prv_i == PRV_S && !envcfg_hi_i[CDE_BIT]) |=> rsp_exc_o == EX_ILLEGAL); // R6
  AST_U_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_prv_i == PRV_U) |=> rsp_exc_o == EX_ILLEGAL); // R7
  AST_EXC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_exc_o != EX_NONE) |-> rsp_rdata_o == '0); // R7
  AST_GUARD_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_prv_i == PRV_S && req_tgt_i == TG_CFG_HI && !req_we_i)
      |=> !rsp_rdata_o[GUARD_BIT]); // R4
  AST_SINH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_prv_i == PRV_S && req_tgt_i == TG_SINH && !req_we_i)
      |=> (rsp_rdata_o & ~XLEN'($past(deleg_mask_i))) == '0); // R8
  AST_DEAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_req && req_prv_i == PRV_M && !req_we_i && dead_win)
      |=> (rsp_rdata_o == '0 && rsp_exc_o == EX_NONE)); // R3
endmodule

bind ctr_deleg_csr ctr_deleg_chk #(
  .XLEN(XLEN), .IDX_W(IDX_W), .IDX_BASE(IDX_BASE), .NSLOT(NSLOT),
  .RESV_OFF(RESV_OFF), .CDE_BIT(CDE_BIT), .GUARD_BIT(GUARD_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_prv_i(req_prv_i),
  .req_tgt_i(req_tgt_i), .req_we_i(req_we_i), .envcfg_hi_i(envcfg_hi_i),
  .deleg_mask_i(deleg_mask_i), .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o), .rsp_exc_o(rsp_exc_o), .index_q(index_q)
);

// File: tb/sim_ctr_deleg_csr.sv
module sim_ctr_deleg_csr;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_prv;
  logic [2:0]  req_tgt;
  logic        req_we;
  logic [31:0] req_wdata;
  logic [31:0] envcfg_hi;
  logic [31:0] deleg_mask;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_exc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [31:0] rd;
    logic [1:0]  ex;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PV = 2'd2, PM = 2'd3;
  localparam logic [2:0] T_IDX = 3'd0, T_CLO = 3'd1, T_FLO = 3'd2, T_CHI = 3'd3,
                         T_FHI = 3'd4, T_SIN = 3'd5, T_MIN = 3'd6, T_BAD = 3'd7;
  localparam logic [1:0] XN = 2'd0, XI = 2'd1, XV = 2'd2;
  localparam logic [31:0] CDE_ON = 32'h1000_0000;

  ctr_deleg_csr u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_prv_i(req_prv),
    .req_tgt_i(req_tgt), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .envcfg_hi_i(envcfg_hi), .deleg_mask_i(deleg_mask),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_exc_o(rsp_exc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic req(input logic [1:0] p, input logic [2:0] t, input logic w,
                     input logic [31:0] d, input logic [31:0] erd,
                     input logic [1:0] eex, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_prv   = p;
    req_tgt   = t;
    req_we    = w;
    req_wdata = d;
    e.rd = erd; e.ex = eex; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic set_env(input logic [31:0] cfg, input logic [31:0] m);
    @(negedge clk);
    req_valid  = 1'b0;
    envcfg_hi  = cfg;
    deleg_mask = m;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL R9: unexpected response rdata=%h exc=%0d expected none", rsp_rdata, rsp_exc);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rsp_rdata !== e.rd || rsp_exc !== e.ex) begin
          bad++;
          $display("FAIL %s: rdata=%h exc=%0d expected rdata=%h exc=%0d",
                   e.tag, rsp_rdata, rsp_exc, e.rd, e.ex);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_prv = PS; req_tgt = T_IDX;
    req_we = 1'b0; req_wdata = '0; envcfg_hi = CDE_ON; deleg_mask = 32'h0000_000D;
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R10: rsp_valid=%b expected 0", rsp_valid);
    end
    rst_n = 1'b1;

    // R10: reset values visible at the ports
    req(PS, T_IDX, 0, 0, 32'h0, XN, "R10");
    req(PM, T_MIN, 0, 0, 32'h0, XN, "R10");
    req(PM, T_CLO, 0, 0, 32'h0, XN, "R10");

    // R2/R9: fill slot 0 from M-mode, guard bit set by machine
    req(PM, T_IDX, 1, 32'h40, 0, XN, "R9");
    req(PM, T_CLO, 1, 32'h1111_0000, 0, XN, "R2");
    req(PM, T_CHI, 1, 32'h0000_2222, 0, XN, "R2");
    req(PM, T_FLO, 1, 32'h0000_3333, 0, XN, "R2");
    req(PM, T_FHI, 1, 32'h4000_0005, 0, XN, "R4");

    // R9: index write then alias access the very next cycle
    req(PS, T_IDX, 1, 32'h42, 0, XN, "R9");
    req(PS, T_CLO, 1, 32'h0000_00AB, 0, XN, "R9");
    req(PS, T_IDX, 1, 32'h40, 0, XN, "R9");
    req(PS, T_CLO, 0, 0, 32'h1111_0000, XN, "R2");
    req(PS, T_CHI, 0, 0, 32'h0000_2222, XN, "R2");
    req(PS, T_FLO, 0, 0, 32'h0000_3333, XN, "R2");
    req(PS, T_FHI, 0, 0, 32'h0000_0005, XN, "R4");
    req(PM, T_FHI, 0, 0, 32'h4000_0005, XN, "R4");

    // R4: S-mode writes leave the guard bit as stored
    req(PS, T_FHI, 1, 32'h0000_0007, 0, XN, "R4");
    req(PM, T_FHI, 0, 0, 32'h4000_0007, XN, "R4");
    req(PS, T_FHI, 1, 32'h4000_0009, 0, XN, "R4");
    req(PM, T_FHI, 0, 0, 32'h4000_0009, XN, "R4");

    // R2: instret and general slots are distinct storage
    req(PS, T_IDX, 1, 32'h42, 0, XN, "R2");
    req(PS, T_CLO, 0, 0, 32'h0000_00AB, XN, "R2");
    req(PS, T_IDX, 1, 32'h43, 0, XN, "R2");
    req(PS, T_FLO, 1, 32'h0000_0055, 0, XN, "R2");
    req(PS, T_FLO, 0, 0, 32'h0000_0055, XN, "R2");
    req(PS, T_CLO, 0, 0, 32'h0, XN, "R2");

    // R3: reserved slot and out-of-window values
    req(PS, T_IDX, 1, 32'h41, 0, XN, "R3");
    req(PS, T_CLO, 1, 32'h0000_0099, 0, XN, "R3");
    req(PS, T_CLO, 0, 0, 32'h0, XN, "R3");
    req(PM, T_CLO, 1, 32'h0000_0099, 0, XN, "R3");
    req(PM, T_CLO, 0, 0, 32'h0, XN, "R3");
    req(PS, T_IDX, 1, 32'h60, 0, XN, "R3");
    req(PS, T_FHI, 1, 32'h1234_5678, 0, XN, "R3");
    req(PS, T_FHI, 0, 0, 32'h0, XN, "R3");
    req(PS, T_IDX, 1, 32'h3F, 0, XN, "R3");
    req(PM, T_CHI, 0, 0, 32'h0, XN, "R3");

    // R6: undelegated slot 4
    req(PS, T_IDX, 1, 32'h44, 0, XN, "R6");
    req(PS, T_CLO, 0, 0, 32'h0, XI, "R6");
    req(PS, T_CLO, 1, 32'h0000_0077, 0, XI, "R6");
    req(PM, T_CLO, 0, 0, 32'h0, XN, "R6");

    // R1/R5/R6: delegation flag handling
    req(PS, T_IDX, 1, 32'h40, 0, XN, "R6");
    set_env(32'hEFFF_FFFF, 32'h0000_000D);
    req(PS, T_CLO, 0, 0, 32'h0, XI, "R1");
    req(PS, T_CLO, 1, 32'hDEAD_0000, 0, XI, "R6");
    req(PV, T_CLO, 0, 0, 32'h0, XI, "R5");
    req(PM, T_CLO, 0, 0, 32'h1111_0000, XN, "R6");
    set_env(CDE_ON, 32'h0000_000D);
    req(PS, T_CLO, 0, 0, 32'h1111_0000, XN, "R1");
    req(PV, T_CHI, 0, 0, 32'h0, XV, "R5");
    req(PV, T_FHI, 1, 32'h0, 0, XV, "R5");

    // R7: privilege and target misuse
    req(PU, T_IDX, 0, 0, 32'h0, XI, "R7");
    req(PU, T_CLO, 0, 0, 32'h0, XI, "R7");
    req(PS, T_BAD, 0, 0, 32'h0, XI, "R7");
    req(PS, T_MIN, 0, 0, 32'h0, XI, "R7");
    req(PV, T_IDX, 0, 0, 32'h0, XV, "R7");
    req(PV, T_SIN, 0, 0, 32'h0, XV, "R7");

    // R8: supervisor inhibit view and discovery
    req(PS, T_SIN, 1, 32'hFFFF_FFFF, 0, XN, "R8");
    req(PS, T_SIN, 0, 0, 32'h0000_000D, XN, "R8");
    req(PM, T_MIN, 0, 0, 32'h0000_000D, XN, "R8");
    req(PM, T_MIN, 1, 32'h0000_0032, 0, XN, "R8");
    req(PS, T_SIN, 0, 0, 32'h0, XN, "R8");
    req(PS, T_SIN, 1, 32'h0, 0, XN, "R8");
    req(PM, T_MIN, 0, 0, 32'h0000_0032, XN, "R8");
    req(PS, T_SIN, 1, 32'hFFFF_FFFF, 0, XN, "R8");
    req(PM, T_MIN, 0, 0, 32'h0000_003F, XN, "R8");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R9: %0d responses missing, expected 0", sb_q.size());
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule